// File: doc/BRIEF.md
# Audio control command decoder

This block sits behind a serial byte receiver in a stereo audio processor. Each received control byte arrives with a one-cycle strobe. The block sorts the byte by its leading prefix bits and writes the matching control register. The registers hold per-channel attenuation, the channel target for volume writes, the soft-mute mode, the loudness boost and the input source.

Volume bytes go to the left channel, the right channel or both. A separately latched target register makes that choice. For each channel the block exposes three things: a coarse 8 dB step index, a fine 1 dB step index and a mute flag. It also gives the total attenuation in dB. Bytes whose prefix is not defined leave every register as it was. The analog path and the timing of the mute ramp are handled elsewhere.

Top module: `audcmd_decoder`

## Requirements
- R1: After reset both channels sit at coarse 0, fine 0, mute flag low, total 0 dB; soft mute is off with the slow speed flag, loudness is off (code 0), the source is input 1 (src_sel = 1) and both target flags are high.
- R2: Bit 7 = 0 marks a volume byte. Bits 7:5 = 100 mark mute/loudness, 101 mark source select and 110 mark channel target. A strobed byte with bits 7:5 = 111, such as 8'hFE, changes no output.
- R3: In a volume byte, bits 2:0 are the fine attenuation, 0 to 7 dB, shown on the fine output.
- R4: In a volume byte, bits 6:3 are the coarse index, shown on the coarse output. Codes 0 to 11 stand for 0 to 88 dB in 8 dB steps.
- R5: A coarse index with bits 3:2 = 11 raises that channel's mute flag, and its total attenuation reads 127.
- R6: A target byte sets the targets from bits 1:0: 00 gives right only, 01 gives left only, 10 or 11 give both. A volume byte changes only the channels that are targeted.
- R7: A source byte maps bits 1:0 onto src_sel: 00 gives 0 (muted input), 11 gives 1 (input 1), 01 gives 2 (input 2), 10 gives 3 (input 3).
- R8: A mute/loudness byte with bit 2 = 0 is a soft-mute subcommand. If bit 1 = 1, soft mute turns off and the speed flag is kept. Otherwise soft mute turns on, with the speed flag set to bit 0 (0 slow, 1 fast).
- R9: A mute/loudness byte with bit 2 = 1 sets loud_level from bits 1:0: x1 gives 0 (off), 00 gives 1 (10 dB), 10 gives 2 (20 dB). The value 3 never appears.
- R10: A channel's total attenuation equals 8 × coarse + fine whenever its mute flag is low.
- R11: Registers update on the clock edge that samples the strobe. A byte presented without the strobe changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | One-cycle strobe for cmd_byte |
| cmd_byte | input | 8 | Received control byte |
| left_coarse | output | 4 | Left coarse 8 dB step index |
| left_fine | output | 3 | Left fine 1 dB step index |
| left_mute | output | 1 | Left volume mute flag |
| left_atten_db | output | 7 | Left total attenuation in dB, 127 when muted |
| right_coarse | output | 4 | Right coarse 8 dB step index |
| right_fine | output | 3 | Right fine 1 dB step index |
| right_mute | output | 1 | Right volume mute flag |
| right_atten_db | output | 7 | Right total attenuation in dB, 127 when muted |
| tgt_left | output | 1 | Volume writes reach left channel |
| tgt_right | output | 1 | Volume writes reach right channel |
| smute_on | output | 1 | Soft mute engaged |
| smute_fast | output | 1 | Soft mute speed: 1 fast, 0 slow |
| loud_level | output | 2 | Loudness: 0 off, 1 10 dB, 2 20 dB |
| src_sel | output | 2 | Source: 0 muted, 1..3 input number |

## Verification
The assertions assume that cmd_valid and cmd_byte are settled at each rising edge. They also assume that every 8-bit value may arrive, including undefined prefixes and back-to-back strobes. The stimulus changes inputs only on falling edges. It draws bytes over the full 0 to 255 range and leaves the strobe low in roughly one cycle of eight. This keeps it inside those assumptions while still reaching the 111 prefix and the mute coarse codes.

// File: rtl/audcmd_pkg.sv
package audcmd_pkg;
  localparam int BYTE_W         = 8;
  localparam int COARSE_W       = 4;
  localparam int FINE_W         = 3;
  localparam int DB_W           = 7;
  localparam int COARSE_STEP_DB = 8;
  localparam int SEL_W          = 2;
  localparam int NUM_CH         = 2;
  localparam logic [DB_W-1:0] MUTE_DB = '1;

  // loudness encodings on loud_level
  localparam logic [SEL_W-1:0] LOUD_OFF = 2'd0;
  localparam logic [SEL_W-1:0] LOUD_10  = 2'd1;
  localparam logic [SEL_W-1:0] LOUD_20  = 2'd2;

  function automatic logic coarse_is_mute(input logic [COARSE_W-1:0] c);
    return c[COARSE_W-1:COARSE_W-2] == 2'b11;
  endfunction

  function automatic logic [DB_W-1:0] total_db(input logic [COARSE_W-1:0] c,
                                              input logic [FINE_W-1:0] f);
    int sum;
    sum = int'(c) * COARSE_STEP_DB + int'(f);
    if (coarse_is_mute(c)) return MUTE_DB;
    return DB_W'(sum);
  endfunction

  // command source code -> input number (0 = muted input)
  function automatic logic [SEL_W-1:0] src_from_code(input logic [SEL_W-1:0] code);
    case (code)
      2'b00:   return 2'd0;
      2'b01:   return 2'd2;
      2'b10:   return 2'd3;
      default: return 2'd1;
    endcase
  endfunction
endpackage

// File: rtl/audcmd_opdec.sv
module audcmd_opdec
  import audcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [BYTE_W-1:0] data,
  output logic              vol_we,
  output logic              mld_we,
  output logic              src_we,
  output logic              tgt_we
);
  logic [2:0] prefix;
  assign prefix = data[BYTE_W-1:BYTE_W-3];

  always_comb begin
    vol_we = 1'b0;
    mld_we = 1'b0;
    src_we = 1'b0;
    tgt_we = 1'b0;
    if (valid) begin
      if (!prefix[2]) vol_we = 1'b1;
      else begin
        case (prefix[1:0])
          2'b00:   mld_we = 1'b1;
          2'b01:   src_we = 1'b1;
          2'b10:   tgt_we = 1'b1;
          default: ;
        endcase
      end
    end
  end

  p_onehot_we_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vol_we, mld_we, src_we, tgt_we}));
  p_reserved_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && prefix == 3'b111) |-> !(vol_we || mld_we || src_we || tgt_we));
  p_no_strobe_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> !(vol_we || mld_we || src_we || tgt_we));
endmodule

// File: rtl/audcmd_vol_chan.sv
module audcmd_vol_chan
  import audcmd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic                targeted,
  input  logic [COARSE_W-1:0] coarse_in,
  input  logic [FINE_W-1:0]   fine_in,
  output logic [COARSE_W-1:0] coarse,
  output logic [FINE_W-1:0]   fine,
  output logic                mute,
  output logic [DB_W-1:0]     atten_db
);
  logic wr_hit;
  assign wr_hit = we && targeted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coarse <= '0;
      fine   <= '0;
    end else if (wr_hit) begin
      coarse <= coarse_in;
      fine   <= fine_in;
    end
  end

  assign mute     = coarse_is_mute(coarse);
  assign atten_db = total_db(coarse, fine);

  p_untargeted_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable({coarse, fine}));
  p_write_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (coarse == $past(coarse_in) && fine == $past(fine_in)));
  p_db_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mute |-> atten_db <= DB_W'(11 * COARSE_STEP_DB + 7));
  p_mute_db_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mute |-> atten_db == MUTE_DB);
endmodule

// File: rtl/audcmd_ctrl.sv
module audcmd_ctrl
  import audcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tgt_we,
  input  logic              mld_we,
  input  logic              src_we,
  input  logic [BYTE_W-1:0] data,
  output logic              tgt_left,
  output logic              tgt_right,
  output logic              smute_on,
  output logic              smute_fast,
  output logic [SEL_W-1:0]  loud_level,
  output logic [SEL_W-1:0]  src_sel
);
  logic is_loud_sub;
  assign is_loud_sub = data[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_left   <= 1'b1;
      tgt_right  <= 1'b1;
      smute_on   <= 1'b0;
      smute_fast <= 1'b0;
      loud_level <= LOUD_OFF;
      src_sel    <= 2'd1;
    end else begin
      if (tgt_we) begin
        tgt_left  <= data[1] | data[0];
        tgt_right <= data[1] | ~data[0];
      end
      if (mld_we) begin
        if (is_loud_sub) begin
          if (data[0])      loud_level <= LOUD_OFF;
          else if (data[1]) loud_level <= LOUD_20;
          else              loud_level <= LOUD_10;
        end else if (data[1]) begin
          smute_on <= 1'b0;
        end else begin
          smute_on   <= 1'b1;
          smute_fast <= data[0];
        end
      end
      if (src_we) src_sel <= src_from_code(data[1:0]);
    end
  end

  p_tgt_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_left || tgt_right);
  p_loud_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    loud_level != 2'd3);
  p_src_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !src_we |=> $stable(src_sel));
  p_mute_engage_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mld_we && !data[2] && !data[1]) |=> smute_on);
  p_speed_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mld_we && !data[2] && data[1]) |=> (!smute_on && $stable(smute_fast)));
  p_loud_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mld_we && is_loud_sub) |=> $stable(loud_level));
endmodule

// File: rtl/audcmd_decoder.sv
module audcmd_decoder
  import audcmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [7:0]  cmd_byte,
  output logic [3:0]  left_coarse,
  output logic [2:0]  left_fine,
  output logic        left_mute,
  output logic [6:0]  left_atten_db,
  output logic [3:0]  right_coarse,
  output logic [2:0]  right_fine,
  output logic        right_mute,
  output logic [6:0]  right_atten_db,
  output logic        tgt_left,
  output logic        tgt_right,
  output logic        smute_on,
  output logic        smute_fast,
  output logic [1:0]  loud_level,
  output logic [1:0]  src_sel
);
  logic vol_we, mld_we, src_we, tgt_we;
  logic [NUM_CH-1:0]   ch_targeted;
  logic [COARSE_W-1:0] ch_coarse [NUM_CH];
  logic [FINE_W-1:0]   ch_fine   [NUM_CH];
  logic                ch_mute   [NUM_CH];
  logic [DB_W-1:0]     ch_db     [NUM_CH];

  audcmd_opdec u_opdec (
    .clk(clk), .rst_n(rst_n), .valid(cmd_valid), .data(cmd_byte),
    .vol_we(vol_we), .mld_we(mld_we), .src_we(src_we), .tgt_we(tgt_we)
  );

  audcmd_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .tgt_we(tgt_we), .mld_we(mld_we),
    .src_we(src_we), .data(cmd_byte),
    .tgt_left(tgt_left), .tgt_right(tgt_right),
    .smute_on(smute_on), .smute_fast(smute_fast),
    .loud_level(loud_level), .src_sel(src_sel)
  );

  // channel 0 = right, channel 1 = left
  assign ch_targeted = {tgt_left, tgt_right};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    audcmd_vol_chan u_vol (
      .clk(clk), .rst_n(rst_n), .we(vol_we), .targeted(ch_targeted[ch]),
      .coarse_in(cmd_byte[FINE_W+COARSE_W-1:FINE_W]),
      .fine_in(cmd_byte[FINE_W-1:0]),
      .coarse(ch_coarse[ch]), .fine(ch_fine[ch]),
      .mute(ch_mute[ch]), .atten_db(ch_db[ch])
    );
  end

  assign right_coarse   = ch_coarse[0];
  assign right_fine     = ch_fine[0];
  assign right_mute     = ch_mute[0];
  assign right_atten_db = ch_db[0];
  assign left_coarse    = ch_coarse[1];
  assign left_fine      = ch_fine[1];
  assign left_mute      = ch_mute[1];
  assign left_atten_db  = ch_db[1];

  p_reserved_no_change_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_byte[7:5] == 3'b111) |=>
      $stable({left_coarse, left_fine, right_coarse, right_fine, tgt_left,
               tgt_right, smute_on, smute_fast, loud_level, src_sel}));
endmodule

// File: tb/audcmd_decoder_test.sv
`timescale 1ns/1ps
module audcmd_decoder_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_byte = '0;
  logic [3:0] left_coarse, right_coarse;
  logic [2:0] left_fine, right_fine;
  logic left_mute, right_mute, tgt_left, tgt_right, smute_on, smute_fast;
  logic [6:0] left_atten_db, right_atten_db;
  logic [1:0] loud_level, src_sel;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // bench model
  int m_lc, m_lf, m_rc, m_rf, m_loud, m_src;
  bit m_tl, m_tr, m_son, m_sf;

  always #4 clk = ~clk;

  audcmd_decoder uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .left_coarse(left_coarse), .left_fine(left_fine), .left_mute(left_mute),
    .left_atten_db(left_atten_db), .right_coarse(right_coarse),
    .right_fine(right_fine), .right_mute(right_mute),
    .right_atten_db(right_atten_db), .tgt_left(tgt_left), .tgt_right(tgt_right),
    .smute_on(smute_on), .smute_fast(smute_fast), .loud_level(loud_level),
    .src_sel(src_sel)
  );

  function automatic int exp_db(int c, int f);
    if (c >= 12) return 127;
    return c * 8 + f;
  endfunction

  function automatic int exp_src(int code);
    if (code == 3) return 1;
    if (code == 0) return 0;
    return code + 1;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_lc = 0; m_lf = 0; m_rc = 0; m_rf = 0; m_loud = 0; m_src = 1;
    m_tl = 1; m_tr = 1; m_son = 0; m_sf = 0;
  endtask

  task automatic model_apply(bit v, logic [7:0] b);
    if (!v) return;
    if (b[7] == 1'b0) begin
      if (m_tl) begin m_lc = int'(b[6:3]); m_lf = int'(b[2:0]); end
      if (m_tr) begin m_rc = int'(b[6:3]); m_rf = int'(b[2:0]); end
    end else if (b[6:5] == 2'b10) begin
      m_tr = (b[1:0] != 2'b01);
      m_tl = (b[1:0] != 2'b00);
    end else if (b[6:5] == 2'b01) begin
      m_src = exp_src(int'(b[1:0]));
    end else if (b[6:5] == 2'b00) begin
      if (b[2]) m_loud = b[0] ? 0 : (b[1] ? 2 : 1);
      else if (b[1]) m_son = 0;
      else begin m_son = 1; m_sf = b[0]; end
    end
  endtask

  task automatic check_all(string ctx);
    chk({ctx, " R3 left fine"}, int'(left_fine), m_lf);
    chk({ctx, " R4 left coarse"}, int'(left_coarse), m_lc);
    chk({ctx, " R5 left mute"}, int'(left_mute), int'(m_lc >= 12));
    chk({ctx, " R10 left dB"}, int'(left_atten_db), exp_db(m_lc, m_lf));
    chk({ctx, " R3 right fine"}, int'(right_fine), m_rf);
    chk({ctx, " R4 right coarse"}, int'(right_coarse), m_rc);
    chk({ctx, " R5 right mute"}, int'(right_mute), int'(m_rc >= 12));
    chk({ctx, " R10 right dB"}, int'(right_atten_db), exp_db(m_rc, m_rf));
    chk({ctx, " R6 targets"}, int'({tgt_left, tgt_right}), int'({m_tl, m_tr}));
    chk({ctx, " R8 soft mute"}, int'({smute_on, smute_fast}), int'({m_son, m_sf}));
    chk({ctx, " R9 loudness"}, int'(loud_level), m_loud);
    chk({ctx, " R7 source"}, int'(src_sel), m_src);
  endtask

  task automatic send(bit v, logic [7:0] b, string ctx);
    @(negedge clk);
    cmd_valid = v;
    cmd_byte = b;
    @(negedge clk);
    cmd_valid = 1'b0;
    model_apply(v, b);
    check_all(ctx);
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset");

    send(1, 8'hFE, "R2 reserved FE");
    send(1, 8'hE3, "R2 reserved E3");
    send(1, 8'h5F, "R4 max 88+7");
    chk("R10 max dB", int'(left_atten_db), 95);
    send(0, 8'h00, "R11 no strobe");
    chk("R11 held dB", int'(left_atten_db), 95);
    send(1, 8'hC1, "R6 left only");
    send(1, 8'h13, "R6 left write");
    chk("R6 right untouched", int'(right_atten_db), 95);
    send(1, 8'hC0, "R6 right only");
    send(1, 8'h60, "R5 coarse 1100");
    chk("R5 right mute dB", int'(right_atten_db), 127);
    send(1, 8'hC2, "R6 both");
    send(1, 8'h7F, "R5 coarse 1111");
    send(1, 8'h81, "R8 fast on");
    send(1, 8'h82, "R8 off keeps speed");
    send(1, 8'h80, "R8 slow on");
    send(1, 8'h84, "R9 10dB");
    send(1, 8'h86, "R9 20dB");
    send(1, 8'h87, "R9 off");
    send(1, 8'hA0, "R7 muted input");
    send(1, 8'hA1, "R7 input2");
    send(1, 8'hA2, "R7 input3");
    send(1, 8'hA3, "R7 input1");

    for (int i = 0; i < 800; i++) begin
      logic [7:0] b;
      bit v;
      b = 8'($urandom);
      v = ($urandom % 8) != 0;
      send(v, b, "R2 random");
    end

    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 second reset");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule